// File: doc/BRIEF.md
# Open-Row Memory Command Sequencer

The block sits between a simple client port and a single-bank DRAM-style device. It turns each client read or write into the commands the device needs: activate a row, read or write a column, precharge, and refresh. It keeps the last activated row open after an access. A later request to that row goes straight to the column command, while a request to another row first closes the open row and then opens the new one. Every accepted request is counted as a hit or a miss.

A free-running interval timer raises a refresh demand. Once the access in progress is finished, the block serves that demand before any new client work. It closes any open row first, then issues a refresh whose row address comes from an internal wrapping counter. Read data is taken from the device bus a fixed number of cycles after the read command, and a one-cycle valid pulse marks it. Write data travels with a byte mask, and a set mask bit keeps that lane unwritten.

Top module: `rowbuf_sequencer`

## Requirements
- R1: After reset the three command strobes are all high (no command), `req_ready` is 1, `rsp_valid` is 0 and both counters are 0.
- R2: Commands are driven as {ras_n,cas_n,we_n}: activate 011, read 101, write 100, precharge 010, refresh 001, none 111. A read or write command appears only while a row is open, meaning an activate has been issued with no precharge since.
- R3: A miss issues an activate only while no row is open. If a row was open, the precharge comes in the cycle after acceptance and the activate follows exactly T_RP cycles later. If no row was open, the activate comes in the cycle after acceptance. The column command follows the activate by exactly T_RCD cycles.
- R4: A hit (the request row equals the open row) issues no precharge and no activate, and its column command appears in the cycle after acceptance.
- R5: Each accepted request adds exactly 1 to either `hit_count` or `miss_count`.
- R6: `rsp_valid` is high for one cycle exactly RD_LAT cycles after each read command, with `rsp_rdata` equal to the device data in that cycle. Responses come back in command order.
- R7: On a write, `dram_wmask` carries `req_wmask`. Bit i covers data bits 8i+7..8i, and a lane is written only when its bit is 0.
- R8: A refresh is issued only while no row is open. An open row is precharged first, and the first request after a refresh is a miss.
- R9: The row address shown with each refresh comes from a counter that starts at 0, increases by one per refresh and wraps after 2^ROW_W refreshes.
- R10: Refresh demands arise every REF_INTERVAL cycles and take priority over client requests, so that under continuous traffic consecutive refreshes stay within a small bounded distance of REF_INTERVAL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Client request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Row in the upper bits, column in the lower COL_W bits |
| req_wdata | input | 8*BYTES | Write data |
| req_wmask | input | BYTES | Byte mask, 1 = lane not written |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 8*BYTES | Read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_row | output | ROW_W | Row for activate, refresh row for refresh |
| dram_col | output | COL_W | Column for read or write |
| dram_wdata | output | 8*BYTES | Write data to the device |
| dram_wmask | output | BYTES | Byte mask to the device |
| dram_rdata | input | 8*BYTES | Read data from the device |
| hit_count | output | CNT_W | Accepted requests that hit the open row |
| miss_count | output | CNT_W | Accepted requests that missed |

## Verification
The bench builds the block with 8 rows of 8 columns, two byte lanes, RD_LAT 3, T_RCD 2, T_RP 2, T_RFC 4 and REF_INTERVAL 300. The small row field lets the refresh counter wrap within ten refreshes. The short interval lets one burst of back-to-back hits run across two refresh demands, which shows whether a refresh is delayed or lost under traffic. The two-lane data path is enough to check each mask bit on its own and both together.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

    // Command codes as {ras_n, cas_n, we_n}
    typedef enum logic [2:0] {
        CMD_NOP = 3'b111,
        CMD_ACT = 3'b011,
        CMD_RD  = 3'b101,
        CMD_WR  = 3'b100,
        CMD_PRE = 3'b010,
        CMD_REF = 3'b001
    } dram_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_TRP,
        ST_TRCD,
        ST_TRFC
    } seq_state_e;

    // Value loaded into a wait counter so that the next command lands t cycles later
    function automatic int unsigned gap_load(input int unsigned t);
        return (t > 0) ? t - 1 : 0;
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic dram_cmd_e access_cmd(input logic is_write);
        return is_write ? CMD_WR : CMD_RD;
    endfunction

endpackage

// File: rtl/rbs_refresh.sv
module rbs_refresh #(
    parameter int unsigned REF_INTERVAL = 7800,
    parameter int unsigned ROW_W        = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_done,
    output logic             ref_pending,
    output logic [ROW_W-1:0] ref_row
);
    localparam int unsigned TMR_W = (REF_INTERVAL > 2) ? $clog2(REF_INTERVAL) : 1;
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(REF_INTERVAL - 1);

    logic [TMR_W-1:0] tmr_q;
    logic             tick;

    assign tick = (tmr_q == TMR_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q       <= '0;
            ref_pending <= 1'b0;
            ref_row     <= '0;
        end else begin
            tmr_q <= tick ? '0 : tmr_q + 1'b1;
            if (tick)
                ref_pending <= 1'b1;
            else if (ref_done)
                ref_pending <= 1'b0;
            if (ref_done)
                ref_row <= ref_row + 1'b1;
        end
    end

endmodule

// File: rtl/rbs_rd_pipe.sv
module rbs_rd_pipe #(
    parameter int unsigned RD_LAT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic rd_cmd,
    output logic rd_ret
);
    generate
        if (RD_LAT <= 1) begin : g_single
            logic stage_q;
            always_ff @(posedge clk) begin
                if (rst) stage_q <= 1'b0;
                else     stage_q <= rd_cmd;
            end
            assign rd_ret = stage_q;
        end else begin : g_chain
            logic [RD_LAT-1:0] stage_q;
            always_ff @(posedge clk) begin
                if (rst) stage_q <= '0;
                else     stage_q <= {stage_q[RD_LAT-2:0], rd_cmd};
            end
            assign rd_ret = stage_q[RD_LAT-1];
        end
    endgenerate

endmodule

// File: rtl/rbs_cmd_fsm.sv
module rbs_cmd_fsm
    import rbs_pkg::*;
#(
    parameter int unsigned ROW_W = 12,
    parameter int unsigned COL_W = 8,
    parameter int unsigned BYTES = 4,
    parameter int unsigned T_RCD = 3,
    parameter int unsigned T_RP  = 3,
    parameter int unsigned T_RFC = 8,
    parameter int unsigned CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [ROW_W-1:0]   req_row,
    input  logic [COL_W-1:0]   req_col,
    input  logic [8*BYTES-1:0] req_wdata,
    input  logic [BYTES-1:0]   req_wmask,
    input  logic               ref_pending,
    input  logic [ROW_W-1:0]   ref_row,
    output dram_cmd_e          cmd,
    output logic [ROW_W-1:0]   cmd_row,
    output logic [COL_W-1:0]   cmd_col,
    output logic [8*BYTES-1:0] cmd_wdata,
    output logic [BYTES-1:0]   cmd_wmask,
    output logic [CNT_W-1:0]   hit_count,
    output logic [CNT_W-1:0]   miss_count
);
    localparam int unsigned DATA_W = 8 * BYTES;
    localparam int unsigned T_MAX  = max3(T_RCD, T_RP, T_RFC);
    localparam int unsigned WT_W   = $clog2(T_MAX + 1);
    localparam logic [WT_W-1:0] LD_RCD = WT_W'(gap_load(T_RCD));
    localparam logic [WT_W-1:0] LD_RP  = WT_W'(gap_load(T_RP));
    localparam logic [WT_W-1:0] LD_RFC = WT_W'(gap_load(T_RFC));

    typedef struct packed {
        logic              wr;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [DATA_W-1:0] wdata;
        logic [BYTES-1:0]  wmask;
    } req_t;

    seq_state_e       state_q;
    logic [WT_W-1:0]  wait_q;
    logic             open_q;
    logic [ROW_W-1:0] open_row_q;
    logic             then_ref_q;
    req_t             held_q;
    req_t             in_req;
    logic             is_hit;

    assign in_req    = '{wr: req_write, row: req_row, col: req_col,
                         wdata: req_wdata, wmask: req_wmask};
    assign is_hit    = open_q && (open_row_q == req_row);
    assign req_ready = (state_q == ST_IDLE) && !ref_pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            wait_q     <= '0;
            open_q     <= 1'b0;
            open_row_q <= '0;
            then_ref_q <= 1'b0;
            held_q     <= '0;
            cmd        <= CMD_NOP;
            cmd_row    <= '0;
            cmd_col    <= '0;
            cmd_wdata  <= '0;
            cmd_wmask  <= '0;
            hit_count  <= '0;
            miss_count <= '0;
        end else begin
            cmd <= CMD_NOP;
            unique case (state_q)
                ST_IDLE: begin
                    if (ref_pending) begin
                        if (open_q) begin
                            cmd        <= CMD_PRE;
                            cmd_row    <= open_row_q;
                            open_q     <= 1'b0;
                            then_ref_q <= 1'b1;
                            wait_q     <= LD_RP;
                            state_q    <= ST_TRP;
                        end else begin
                            cmd     <= CMD_REF;
                            cmd_row <= ref_row;
                            wait_q  <= LD_RFC;
                            state_q <= ST_TRFC;
                        end
                    end else if (req_valid) begin
                        held_q <= in_req;
                        if (is_hit) begin
                            hit_count <= hit_count + 1'b1;
                            cmd       <= access_cmd(in_req.wr);
                            cmd_col   <= in_req.col;
                            cmd_wdata <= in_req.wdata;
                            cmd_wmask <= in_req.wmask;
                        end else begin
                            miss_count <= miss_count + 1'b1;
                            if (open_q) begin
                                cmd        <= CMD_PRE;
                                cmd_row    <= open_row_q;
                                open_q     <= 1'b0;
                                then_ref_q <= 1'b0;
                                wait_q     <= LD_RP;
                                state_q    <= ST_TRP;
                            end else begin
                                cmd        <= CMD_ACT;
                                cmd_row    <= in_req.row;
                                open_q     <= 1'b1;
                                open_row_q <= in_req.row;
                                wait_q     <= LD_RCD;
                                state_q    <= ST_TRCD;
                            end
                        end
                    end
                end
                ST_TRP: begin
                    if (wait_q != '0) begin
                        wait_q <= wait_q - 1'b1;
                    end else if (then_ref_q) begin
                        cmd     <= CMD_REF;
                        cmd_row <= ref_row;
                        wait_q  <= LD_RFC;
                        state_q <= ST_TRFC;
                    end else begin
                        cmd        <= CMD_ACT;
                        cmd_row    <= held_q.row;
                        open_q     <= 1'b1;
                        open_row_q <= held_q.row;
                        wait_q     <= LD_RCD;
                        state_q    <= ST_TRCD;
                    end
                end
                ST_TRCD: begin
                    if (wait_q != '0) begin
                        wait_q <= wait_q - 1'b1;
                    end else begin
                        cmd       <= access_cmd(held_q.wr);
                        cmd_col   <= held_q.col;
                        cmd_wdata <= held_q.wdata;
                        cmd_wmask <= held_q.wmask;
                        state_q   <= ST_IDLE;
                    end
                end
                ST_TRFC: begin
                    if (wait_q != '0) wait_q <= wait_q - 1'b1;
                    else              state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rowbuf_sequencer.sv
module rowbuf_sequencer
    import rbs_pkg::*;
#(
    parameter int unsigned ROW_W        = 12,
    parameter int unsigned COL_W        = 8,
    parameter int unsigned BYTES        = 4,
    parameter int unsigned RD_LAT       = 4,
    parameter int unsigned T_RCD        = 3,
    parameter int unsigned T_RP         = 3,
    parameter int unsigned T_RFC        = 8,
    parameter int unsigned REF_INTERVAL = 7800,
    parameter int unsigned CNT_W        = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [ROW_W+COL_W-1:0] req_addr,
    input  logic [8*BYTES-1:0]     req_wdata,
    input  logic [BYTES-1:0]       req_wmask,
    output logic                   rsp_valid,
    output logic [8*BYTES-1:0]     rsp_rdata,
    output logic                   dram_ras_n,
    output logic                   dram_cas_n,
    output logic                   dram_we_n,
    output logic [ROW_W-1:0]       dram_row,
    output logic [COL_W-1:0]       dram_col,
    output logic [8*BYTES-1:0]     dram_wdata,
    output logic [BYTES-1:0]       dram_wmask,
    input  logic [8*BYTES-1:0]     dram_rdata,
    output logic [CNT_W-1:0]       hit_count,
    output logic [CNT_W-1:0]       miss_count
);
    localparam int unsigned ADDR_W = ROW_W + COL_W;

    dram_cmd_e        cmd;
    logic             ref_pending;
    logic [ROW_W-1:0] ref_row;
    logic             ref_done;
    logic             rd_ret;

    assign ref_done = (cmd == CMD_REF);
    assign {dram_ras_n, dram_cas_n, dram_we_n} = cmd;

    rbs_refresh #(
        .REF_INTERVAL(REF_INTERVAL),
        .ROW_W       (ROW_W)
    ) i_refresh (
        .clk        (clk),
        .rst        (rst),
        .ref_done   (ref_done),
        .ref_pending(ref_pending),
        .ref_row    (ref_row)
    );

    rbs_cmd_fsm #(
        .ROW_W(ROW_W),
        .COL_W(COL_W),
        .BYTES(BYTES),
        .T_RCD(T_RCD),
        .T_RP (T_RP),
        .T_RFC(T_RFC),
        .CNT_W(CNT_W)
    ) i_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_row    (req_addr[ADDR_W-1:COL_W]),
        .req_col    (req_addr[COL_W-1:0]),
        .req_wdata  (req_wdata),
        .req_wmask  (req_wmask),
        .ref_pending(ref_pending),
        .ref_row    (ref_row),
        .cmd        (cmd),
        .cmd_row    (dram_row),
        .cmd_col    (dram_col),
        .cmd_wdata  (dram_wdata),
        .cmd_wmask  (dram_wmask),
        .hit_count  (hit_count),
        .miss_count (miss_count)
    );

    rbs_rd_pipe #(
        .RD_LAT(RD_LAT)
    ) i_rd_pipe (
        .clk   (clk),
        .rst   (rst),
        .rd_cmd(cmd == CMD_RD),
        .rd_ret(rd_ret)
    );

    assign rsp_valid = rd_ret;
    assign rsp_rdata = rd_ret ? dram_rdata : '0;

endmodule

// File: rtl/rbs_checker.sv
module rbs_checker #(
    parameter int unsigned T_RCD = 3,
    parameter int unsigned T_RP  = 3,
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             dram_ras_n,
    input logic             dram_cas_n,
    input logic             dram_we_n,
    input logic             rsp_valid,
    input logic [CNT_W-1:0] hit_count,
    input logic [CNT_W-1:0] miss_count
);
    localparam int unsigned GAP_MAX = ((T_RCD > T_RP) ? T_RCD : T_RP) + 2;
    localparam int unsigned GW      = $clog2(GAP_MAX + 1);
    localparam logic [GW-1:0] GSAT  = GW'(GAP_MAX);

    logic [2:0] code;
    logic is_act, is_pre, is_rd, is_wr, is_ref, is_acc;
    logic trk_open;
    logic [GW-1:0] since_act, since_pre;
    logic [7:0] rd_out;

    assign code   = {dram_ras_n, dram_cas_n, dram_we_n};
    assign is_act = (code == 3'b011);
    assign is_pre = (code == 3'b010);
    assign is_rd  = (code == 3'b101);
    assign is_wr  = (code == 3'b100);
    assign is_ref = (code == 3'b001);
    assign is_acc = is_rd || is_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            trk_open  <= 1'b0;
            since_act <= GSAT;
            since_pre <= GSAT;
            rd_out    <= '0;
        end else begin
            if (is_act)                 trk_open <= 1'b1;
            else if (is_pre || is_ref)  trk_open <= 1'b0;
            since_act <= is_act ? GW'(1) : ((since_act == GSAT) ? GSAT : since_act + 1'b1);
            since_pre <= is_pre ? GW'(1) : ((since_pre == GSAT) ? GSAT : since_pre + 1'b1);
            rd_out    <= rd_out + {7'd0, is_rd} - {7'd0, rsp_valid};
        end
    end

    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (code == 3'b111));

    assert_access_open_R2: assert property (@(posedge clk) disable iff (rst)
        is_acc |-> trk_open);

    assert_act_closed_R3: assert property (@(posedge clk) disable iff (rst)
        is_act |-> !trk_open);

    assert_pre_to_act_R3: assert property (@(posedge clk) disable iff (rst)
        is_act |-> (since_pre >= GW'(T_RP)));

    assert_act_to_access_R3: assert property (@(posedge clk) disable iff (rst)
        is_acc |-> (since_act >= GW'(T_RCD)));

    assert_hit_step_R5: assert property (@(posedge clk) disable iff (rst)
        (hit_count == $past(hit_count)) || (hit_count == $past(hit_count) + 1'b1));

    assert_miss_step_R5: assert property (@(posedge clk) disable iff (rst)
        (miss_count == $past(miss_count)) || (miss_count == $past(miss_count) + 1'b1));

    assert_rsp_has_read_R6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rd_out != 8'd0));

    assert_ref_closed_R8: assert property (@(posedge clk) disable iff (rst)
        is_ref |-> !trk_open);

endmodule

bind rowbuf_sequencer rbs_checker #(
    .T_RCD(T_RCD),
    .T_RP (T_RP),
    .CNT_W(CNT_W)
) i_rbs_checker (
    .clk       (clk),
    .rst       (rst),
    .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n),
    .dram_we_n (dram_we_n),
    .rsp_valid (rsp_valid),
    .hit_count (hit_count),
    .miss_count(miss_count)
);

// File: tb/test_rowbuf_sequencer.sv
module test_rowbuf_sequencer;
    localparam int CLK_PERIOD   = 10;
    localparam int ROW_W        = 3;
    localparam int COL_W        = 3;
    localparam int BYTES        = 2;
    localparam int DW           = 8 * BYTES;
    localparam int RD_LAT       = 3;
    localparam int T_RCD        = 2;
    localparam int T_RP         = 2;
    localparam int T_RFC        = 4;
    localparam int REF_INTERVAL = 300;
    localparam int CNT_W        = 16;
    localparam int SLACK        = 16;
    localparam int WD_LIMIT     = 50000;
    localparam int NV           = 12;

    // {wr, row, col, wdata, mask, exp_hit, exp_rdata}
    localparam logic [41:0] TBL [NV] = '{
        {1'b1, 3'd1, 3'd2, 16'h1234, 2'b00, 1'b0, 16'h0000},
        {1'b0, 3'd1, 3'd2, 16'h0000, 2'b00, 1'b1, 16'h1234},
        {1'b1, 3'd1, 3'd2, 16'hABCD, 2'b01, 1'b1, 16'h0000},
        {1'b0, 3'd1, 3'd2, 16'h0000, 2'b00, 1'b1, 16'hAB34},
        {1'b1, 3'd5, 3'd0, 16'h5A5A, 2'b00, 1'b0, 16'h0000},
        {1'b0, 3'd1, 3'd2, 16'h0000, 2'b00, 1'b0, 16'hAB34},
        {1'b1, 3'd1, 3'd7, 16'hFFFF, 2'b10, 1'b1, 16'h0000},
        {1'b0, 3'd1, 3'd7, 16'h0000, 2'b00, 1'b1, 16'h00FF},
        {1'b0, 3'd5, 3'd0, 16'h0000, 2'b00, 1'b0, 16'h5A5A},
        {1'b1, 3'd5, 3'd0, 16'h1111, 2'b11, 1'b1, 16'h0000},
        {1'b0, 3'd5, 3'd0, 16'h0000, 2'b00, 1'b1, 16'h5A5A},
        {1'b0, 3'd3, 3'd4, 16'h0000, 2'b00, 1'b0, 16'h0000}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_ready;
    logic req_write = 1'b0;
    logic [ROW_W+COL_W-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [BYTES-1:0] req_wmask = '0;
    logic rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic ras_n, cas_n, we_n;
    logic [ROW_W-1:0] dram_row;
    logic [COL_W-1:0] dram_col;
    logic [DW-1:0] dram_wdata;
    logic [BYTES-1:0] dram_wmask;
    logic [DW-1:0] dram_rdata;
    logic [CNT_W-1:0] hit_count, miss_count;

    always #(CLK_PERIOD/2) clk = ~clk;

    rowbuf_sequencer #(
        .ROW_W(ROW_W), .COL_W(COL_W), .BYTES(BYTES), .RD_LAT(RD_LAT),
        .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC),
        .REF_INTERVAL(REF_INTERVAL), .CNT_W(CNT_W)
    ) i_rowbuf_sequencer (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_wmask(req_wmask),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n),
        .dram_row(dram_row), .dram_col(dram_col),
        .dram_wdata(dram_wdata), .dram_wmask(dram_wmask), .dram_rdata(dram_rdata),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // ---------------- behavioural device: array + one row buffer ----------------
    logic [DW-1:0] mem [64];
    logic [DW-1:0] rowbuf [8];
    logic          d_open = 1'b0;
    logic [2:0]    d_row  = '0;
    logic          dq_v [RD_LAT];
    logic [DW-1:0] dq_d [RD_LAT];

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        for (int i = 0; i < 8; i++) rowbuf[i] = '0;
        for (int i = 0; i < RD_LAT; i++) begin dq_v[i] = 1'b0; dq_d[i] = '0; end
    end

    always @(posedge clk) begin
        logic [2:0] code;
        code = {ras_n, cas_n, we_n};
        for (int i = RD_LAT - 1; i > 0; i--) begin
            dq_v[i] = dq_v[i-1];
            dq_d[i] = dq_d[i-1];
        end
        dq_v[0] = (code == 3'b101);
        dq_d[0] = (code == 3'b101 && d_open) ? rowbuf[dram_col] : 16'hDEAD;
        case (code)
            3'b011: begin
                for (int c = 0; c < 8; c++) rowbuf[c] = mem[{dram_row, 3'(c)}];
                d_open = 1'b1;
                d_row  = dram_row;
            end
            3'b010: begin
                if (d_open)
                    for (int c = 0; c < 8; c++) mem[{d_row, 3'(c)}] = rowbuf[c];
                d_open = 1'b0;
            end
            3'b100: begin
                for (int b = 0; b < BYTES; b++)
                    if (!dram_wmask[b]) rowbuf[dram_col][8*b +: 8] = dram_wdata[8*b +: 8];
            end
            default: ;
        endcase
    end
    assign dram_rdata = dq_v[RD_LAT-1] ? dq_d[RD_LAT-1] : '0;

    // ---------------- pin monitor ----------------
    int m_chk = 0, m_fail = 0;
    int n_act = 0, n_pre = 0, n_acc = 0, n_ref = 0, n_rsp = 0;
    int last_act = 0, last_pre = 0, last_acc = 0, last_ref = 0;
    logic t_open = 1'b0;
    logic [DW-1:0] last_rdata = '0;
    logic [BYTES-1:0] last_wmask = '0;
    int rdq [$];
    bit done = 1'b0;

    task automatic mcheck(input bit ok, input string tag, input logic [31:0] act,
                          input logic [31:0] exp);
        m_chk++;
        if (!ok) begin
            m_fail++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            case ({ras_n, cas_n, we_n})
                3'b011: begin n_act++; last_act = cyc; t_open = 1'b1; end
                3'b010: begin n_pre++; last_pre = cyc; t_open = 1'b0; end
                3'b101, 3'b100: begin
                    mcheck(t_open, "R2 access with no open row", 32'(t_open), 1);
                    n_acc++; last_acc = cyc;
                    if (!we_n) last_wmask = dram_wmask;
                    else       rdq.push_back(cyc);
                end
                3'b001: begin
                    mcheck(!t_open, "R8 refresh with row open", 32'(t_open), 0);
                    mcheck(dram_row == 3'(n_ref % 8), "R9 refresh row", 32'(dram_row),
                           32'(n_ref % 8));
                    if (n_ref > 0)
                        mcheck((cyc - last_ref <= REF_INTERVAL + SLACK) &&
                               (cyc - last_ref >= REF_INTERVAL - SLACK),
                               "R10 refresh spacing", 32'(cyc - last_ref), REF_INTERVAL);
                    n_ref++; last_ref = cyc;
                end
                default: ;
            endcase
            if (rsp_valid) begin
                if (rdq.size() == 0) begin
                    mcheck(1'b0, "R6 response without read", 1, 0);
                end else begin
                    mcheck(cyc - rdq[0] == RD_LAT, "R6 read latency", 32'(cyc - rdq[0]),
                           RD_LAT);
                    void'(rdq.pop_front());
                end
                mcheck(rsp_rdata == dram_rdata, "R6 rdata passthrough", 32'(rsp_rdata),
                       32'(dram_rdata));
                last_rdata = rsp_rdata;
                n_rsp++;
            end
        end
        if (cyc > WD_LIMIT && !done) begin
            m_fail++;
            $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, WD_LIMIT);
            $display("End of test - %0d assertions evaluated, %0d failures", m_chk + 1,
                     m_fail);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    int n_chk = 0, n_fail = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic send(input logic wr, input logic [2:0] row, input logic [2:0] col,
                        input logic [DW-1:0] data, input logic [BYTES-1:0] mask,
                        output int acc_cyc);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = {row, col};
        req_wdata = data;
        req_wmask = mask;
        while (!req_ready) @(negedge clk);
        acc_cyc = cyc;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        int acc_c, h0, m0, a0, p0, c0, r0, refs0;
        logic was_open;
        logic [41:0] e;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle state right after reset
        check({ras_n, cas_n, we_n} == 3'b111, "R1 strobes idle", 32'({ras_n, cas_n, we_n}), 7);
        check(req_ready == 1'b1, "R1 ready", 32'(req_ready), 1);
        check(rsp_valid == 1'b0, "R1 rsp_valid", 32'(rsp_valid), 0);
        check(hit_count == 0 && miss_count == 0, "R1 counters", 32'(hit_count + miss_count), 0);

        for (int i = 0; i < NV; i++) begin
            e = TBL[i];
            h0 = 32'(hit_count); m0 = 32'(miss_count);
            a0 = n_act; p0 = n_pre; c0 = n_acc; r0 = n_rsp;
            was_open = t_open;
            send(e[41], e[40:38], e[37:35], e[34:19], e[18:17], acc_c);
            while (n_acc == c0) @(negedge clk);
            if (!e[41]) while (n_rsp == r0) @(negedge clk);
            @(negedge clk);
            if (e[16]) begin
                check(32'(hit_count) == h0 + 1, "R5 hit count", 32'(hit_count), h0 + 1);
                check(last_acc == acc_c + 1, "R4 hit command cycle", last_acc, acc_c + 1);
                check(n_act == a0 && n_pre == p0, "R4 no row commands on hit",
                      n_act + n_pre, a0 + p0);
            end else begin
                check(32'(miss_count) == m0 + 1, "R5 miss count", 32'(miss_count), m0 + 1);
                check(last_acc - last_act == T_RCD, "R3 act to access", last_acc - last_act,
                      T_RCD);
                if (was_open) begin
                    check(last_pre == acc_c + 1, "R3 precharge cycle", last_pre, acc_c + 1);
                    check(last_act - last_pre == T_RP, "R3 precharge to act",
                          last_act - last_pre, T_RP);
                end else begin
                    check(last_act == acc_c + 1, "R3 act cycle", last_act, acc_c + 1);
                end
            end
            if (e[41])
                check(last_wmask == e[18:17], "R7 mask forwarded", 32'(last_wmask),
                      32'(e[18:17]));
            else
                check(last_rdata == e[15:0], "R7 read back data", 32'(last_rdata),
                      32'(e[15:0]));
        end
        check(hit_count == 7 && miss_count == 5, "R5 totals", 32'({hit_count, miss_count}),
              32'({16'd7, 16'd5}));

        // R8: refresh closes the row left open by the table; next request misses
        while (n_ref < 1) @(negedge clk);
        check(t_open == 1'b0, "R8 row closed after refresh", 32'(t_open), 0);
        m0 = 32'(miss_count); c0 = n_acc; r0 = n_rsp; a0 = n_act;
        send(1'b0, 3'd3, 3'd4, '0, '0, acc_c);
        while (n_rsp == r0) @(negedge clk);
        check(32'(miss_count) == m0 + 1, "R8 miss after refresh", 32'(miss_count), m0 + 1);
        check(n_act == a0 + 1, "R8 reactivate after refresh", n_act, a0 + 1);

        // R10: continuous hits across refresh demands
        refs0 = n_ref; m0 = 32'(miss_count); h0 = 32'(hit_count);
        for (int i = 0; i < 700; i++) begin
            @(negedge clk);
            req_valid = 1'b1;
            req_write = 1'b0;
            req_addr  = {3'd3, 3'(i)};
            while (!req_ready) @(negedge clk);
        end
        @(negedge clk);
        req_valid = 1'b0;
        check(n_ref - refs0 >= 2, "R10 refresh not starved", n_ref - refs0, 2);
        check(32'(miss_count) - m0 == n_ref - refs0, "R8 one miss per refresh",
              32'(miss_count) - m0, n_ref - refs0);
        check(32'(hit_count) - h0 + 32'(miss_count) - m0 == 700, "R5 stream total",
              32'(hit_count) - h0 + 32'(miss_count) - m0, 700);

        // R9: let the refresh row counter wrap
        while (n_ref < 10) @(negedge clk);
        repeat (RD_LAT + 2) @(negedge clk);
        check(rdq.size() == 0, "R6 all reads answered", rdq.size(), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk + m_chk,
                 n_fail + m_fail);
        $finish;
    end

endmodule